// File: doc/BRIEF.md
# Absolute-Address Command Frame Serialiser

This block turns one read or write request into an absolute-address command frame and shifts it out over a two-wire clocked master link. The link has a master-driven clock and a single data line. The request names a 2-bit target id, a 21-bit address, an access width of 8, 16 or 32 bits and, for writes, the data. The block packs these fields into a frame whose length depends on the request. It folds a leading start bit and every frame bit into a 4-bit serial CRC and appends the CRC. It then sends start bit, frame and CRC most significant bit first. Each logical bit is driven inverted, so the line is active-low.

After the last CRC bit, the block holds the data line high for an echo window of link clocks. During this window line reflections die out before the target answers. The data-line output enable and the level-translator direction output stay high from acceptance to the end of the echo window. Both fall together when the block returns to idle, which hands the line over for reception. The link clock period is set by a half-period input counted in system clocks.

A controller presents a request with a valid/ready handshake. It then waits for the one-cycle completion pulse before it listens for the response on the same line.

Top module: `cmdlink_tx`

## Requirements
- R1: After the start bit, the frame begins with the target id (2 bits, MSB first), then a constant 1, then two 0s, then a read flag (1 = read, 0 = write), then the 21-bit address MSB first.
- R2: The width code `req_size_i` is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. The bit after the address is 1 for 16- and 32-bit accesses. For 32-bit accesses the address LSB position is also forced to 1. For 8-bit accesses both bits are carried unchanged (address LSB, then 0).
- R3: A read frame is 28 bits long. A write frame appends the low 8, 16 or 32 bits of `req_wdata_i`, MSB first, right after those 28 bits, giving 36, 44 or 60 bits.
- R4: Right after the frame come 4 CRC bits, MSB first. The CRC starts at 0 and takes one step for the start bit (a 1) and one step for each frame bit in order. A step with input b is: m = b XOR c[3]; c = {c[2:0],0} XOR {0,m,m,m}.
- R5: A start bit of logical 1 leads each frame. One logical bit is sent per link clock period, valid at the rising link clock edge. `link_data_o` carries the inverse of the logical bit.
- R6: Each link clock period is a low half followed by a high half. Each half lasts max(`half_period_i`,1) system clocks, with the value captured when the request is accepted. `link_data_o` changes only in cycles where `link_clk_o` is low.
- R7: After the last CRC bit, `link_data_o` is held high for 16 further link clock periods (the echo window).
- R8: `link_oe_o` and `xlat_dir_o` are 1 from the cycle after acceptance to the end of the echo window. Both are 0 while idle.
- R9: `req_ready_o` is 1 only while idle, and a request is taken on a cycle with both valid and ready high. Request inputs offered while busy have no effect on the frame being sent.
- R10: `done_o` pulses for exactly one cycle. It is high in the cycle that follows system edge k + 2·H·(N+16), where k is the accepting edge, H the effective half period and N = 1 + frame length + 4.
- R11: During and after reset, `req_ready_o`=1, `link_clk_o`=1, `link_data_o`=1, `link_oe_o`=0, `xlat_dir_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_slave_i | input | 2 | Target id |
| req_addr_i | input | 21 | Target address |
| req_size_i | input | 2 | Access width code (0: 8, 1: 16, 2/3: 32 bits) |
| req_wdata_i | input | 32 | Write data, right-aligned |
| half_period_i | input | 8 | Link clock half period in system clocks (0 acts as 1) |
| done_o | output | 1 | One-cycle pulse when frame and echo window have finished |
| link_clk_o | output | 1 | Link clock, idles high |
| link_data_o | output | 1 | Data line drive value, active-low |
| link_oe_o | output | 1 | Data line output enable |
| xlat_dir_o | output | 1 | Level translator direction, 1 = master driving |

## Verification
The bench sends all three widths as writes and reads and compares every bit captured on rising link clock edges with an independently built frame. A wrong size bit, an address-overlap slip or a CRC that skipped the start bit would each show up as a single flipped bit in the middle or tail of the stream. It sends frames with half periods of 0, 1 and 3 and counts the system cycles to `done_o`. An off-by-one in the divider or the echo counter would move that pulse by whole half periods. It also watches for data edges during a high clock phase, which would create a false sample at the target. Finally, it keeps a different request valid during a frame. A block that re-latched fields while busy would corrupt the stream or start a second frame.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

  localparam int FRAME_W   = 64;
  localparam int CRC_W     = 4;
  localparam int HDR_LEN   = 28;
  localparam int LEN_W     = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_ECHO  = 2'd2
  } tx_state_e;

  function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] c, input logic b);
    logic m;
    m = b ^ c[3];
    return {c[2:0], 1'b0} ^ {1'b0, m, m, m};
  endfunction

endpackage

// File: rtl/cmdlink_framer.sv
module cmdlink_framer
  import cmdlink_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input  logic               rd_i,
  input  logic [1:0]         slave_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   nbits_o
);
  localparam int ADDR_LSB = FRAME_W - 1 - 6 - ADDR_W + 1;

  logic [FRAME_W-1:0] word;
  logic [LEN_W-1:0]   len;
  logic [CRC_W-1:0]   crc;
  int                 pos;

  always_comb begin
    word = '0;
    word[63:62] = slave_i;
    word[61]    = 1'b1;
    word[58]    = rd_i;
    word[ADDR_LSB +: ADDR_W] = addr_i;
    len = LEN_W'(HDR_LEN);
    case (size_i)
      2'd0: begin
        if (!rd_i) begin
          word[35:28] = wdata_i[7:0];
          len = LEN_W'(HDR_LEN + 8);
        end
      end
      2'd1: begin
        word[36] = 1'b1;
        if (!rd_i) begin
          word[35:20] = wdata_i[15:0];
          len = LEN_W'(HDR_LEN + 16);
        end
      end
      default: begin
        word[37] = 1'b1;
        word[36] = 1'b1;
        if (!rd_i) begin
          word[35:4] = wdata_i[31:0];
          len = LEN_W'(HDR_LEN + 32);
        end
      end
    endcase

    // start bit is folded in first, then each frame bit in order
    crc = crc4_step('0, 1'b1);
    for (int i = 0; i < FRAME_W - CRC_W; i++) begin
      if (i < int'(len)) crc = crc4_step(crc, word[FRAME_W-1-i]);
    end
    pos = FRAME_W - 1 - int'(len);
    word[pos -: CRC_W] = crc;

    frame_o = word;
    nbits_o = len + LEN_W'(CRC_W);
  end

endmodule

// File: rtl/cmdlink_tick.sv
module cmdlink_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] limit;

  assign limit  = (half_q == '0) ? DIV_W'(0) : half_q - DIV_W'(1);
  assign tick_o = run_i && (cnt_q >= limit);

  always_comb begin
    half_d = load_i ? half_i : half_q;
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      cnt_q  <= '0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end

  a_r6_tick_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (cnt_q <= half_q));

endmodule

// File: rtl/cmdlink_shifter.sv
module cmdlink_shifter
  import cmdlink_pkg::*;
#(
  parameter int ECHO_CLKS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   nbits_i,
  input  logic               tick_i,
  output logic               busy_o,
  output logic               lclk_o,
  output logic               ldat_o,
  output logic               oe_o,
  output logic               done_o
);
  localparam int ECHO_W = $clog2(ECHO_CLKS + 1);

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic [ECHO_W-1:0]  echo_q, echo_d;
  logic               lclk_q, lclk_d;
  logic               ldat_q, ldat_d;
  logic               oe_q, oe_d;
  logic               done_q, done_d;

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    left_d  = left_q;
    echo_d  = echo_q;
    lclk_d  = lclk_q;
    ldat_d  = ldat_q;
    oe_d    = oe_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FRAME;
          sr_d    = frame_i;
          left_d  = nbits_i + LEN_W'(1);
          lclk_d  = 1'b0;
          ldat_d  = 1'b0;          // start bit, logical 1 inverted
          oe_d    = 1'b1;
        end
      end
      ST_FRAME: begin
        if (tick_i) begin
          if (!lclk_q) begin
            lclk_d = 1'b1;
          end else if (left_q > LEN_W'(1)) begin
            left_d = left_q - LEN_W'(1);
            ldat_d = ~sr_q[FRAME_W-1];
            sr_d   = sr_q << 1;
            lclk_d = 1'b0;
          end else begin
            state_d = ST_ECHO;
            echo_d  = ECHO_W'(ECHO_CLKS - 1);
            ldat_d  = 1'b1;
            lclk_d  = 1'b0;
          end
        end
      end
      ST_ECHO: begin
        if (tick_i) begin
          if (!lclk_q) begin
            lclk_d = 1'b1;
          end else if (echo_q != '0) begin
            echo_d = echo_q - ECHO_W'(1);
            lclk_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      left_q  <= '0;
      echo_q  <= '0;
      lclk_q  <= 1'b1;
      ldat_q  <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      left_q  <= left_d;
      echo_q  <= echo_d;
      lclk_q  <= lclk_d;
      ldat_q  <= ldat_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign lclk_o = lclk_q;
  assign ldat_o = ldat_q;
  assign oe_o   = oe_q;
  assign done_o = done_q;

  a_r6_data_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ldat_q != $past(ldat_q)) |-> !lclk_q);

  a_r6_clk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (lclk_q != $past(lclk_q)) |-> ($past(tick_i) || $past(start_i)));

  a_r7_echo_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ECHO) |-> ldat_q);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/cmdlink_tx.sv
module cmdlink_tx
  import cmdlink_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 8,
  parameter int ECHO_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_rd_i,
  input  logic [1:0]        req_slave_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DIV_W-1:0]  half_period_i,
  output logic              done_o,
  output logic              link_clk_o,
  output logic              link_data_o,
  output logic              link_oe_o,
  output logic              xlat_dir_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               busy;
  logic               accept;
  logic               tick;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   nbits;
  logic               oe;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && !busy;

  cmdlink_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
    .rd_i    (req_rd_i),
    .slave_i (req_slave_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .wdata_i (req_wdata_i),
    .frame_o (frame),
    .nbits_o (nbits)
  );

  cmdlink_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (accept),
    .half_i (half_period_i),
    .run_i  (busy),
    .tick_o (tick)
  );

  cmdlink_shifter #(.ECHO_CLKS(ECHO_CLKS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (accept),
    .frame_i (frame),
    .nbits_i (nbits),
    .tick_i  (tick),
    .busy_o  (busy),
    .lclk_o  (link_clk_o),
    .ldat_o  (link_data_o),
    .oe_o    (oe),
    .done_o  (done_o)
  );

  assign link_oe_o  = oe;
  assign xlat_dir_o = oe;

  a_r9_ready_drop_on_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(req_ready_o) |-> $past(req_valid_i));

  a_r8_oe_while_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    link_oe_o |-> !req_ready_o);

  a_r11_idle_line: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_ready_o && !done_o && !$past(done_o)) |-> (link_clk_o && link_data_o && !link_oe_o));

endmodule

// File: tb/sim_cmdlink_tx.sv
module sim_cmdlink_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_rd = 1'b0;
  logic [1:0]  req_slave = '0;
  logic [20:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  half = 8'd1;
  logic        req_ready, done, lclk, ldat, loe, xdir;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bit exp_b [0:127];
  int exp_n;
  bit capt [0:127];
  int cap_n = 0;
  int oe_bad = 0;
  int edge_bad = 0;
  bit cap_en = 1'b0;
  logic prev_dat = 1'b1;

  always #10 clk = ~clk;

  cmdlink_tx u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_rd_i(req_rd), .req_slave_i(req_slave), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata), .half_period_i(half),
    .done_o(done), .link_clk_o(lclk), .link_data_o(ldat),
    .link_oe_o(loe), .xlat_dir_o(xdir)
  );

  always @(posedge lclk) begin
    if (cap_en) begin
      if (cap_n < 128) capt[cap_n] = ~ldat;
      cap_n++;
      if (!(loe && xdir)) oe_bad++;
    end
  end

  always @(negedge clk) begin
    if (ldat !== prev_dat && lclk !== 1'b0) edge_bad++;
    prev_dat = ldat;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] step(input logic [3:0] c, input bit b);
    bit m;
    m = b ^ c[3];
    return {c[2:0], 1'b0} ^ {1'b0, m, m, m};
  endfunction

  task automatic push(input bit b);
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic build(input bit rd, input logic [1:0] sl, input logic [20:0] ad,
                       input logic [1:0] sz, input logic [31:0] wd);
    logic [3:0] c;
    int dw;
    exp_n = 0;
    push(1'b1);
    push(sl[1]); push(sl[0]);
    push(1'b1); push(1'b0); push(1'b0);
    push(rd);
    for (int i = 20; i >= 1; i--) push(ad[i]);
    push(ad[0] | (sz >= 2'd2));
    push(sz != 2'd0);
    dw = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    if (!rd) for (int i = dw - 1; i >= 0; i--) push(wd[i]);
    c = 4'd0;
    for (int i = 0; i < exp_n; i++) c = step(c, exp_b[i]);
    for (int i = 3; i >= 0; i--) push(c[i]);
  endtask

  // send one request, check stream, echo window, line control and timing
  task automatic run_frame(input string tag, input bit rd, input logic [1:0] sl,
                           input logic [20:0] ad, input logic [1:0] sz,
                           input logic [31:0] wd, input logic [7:0] hp,
                           input bit noisy);
    int n, bad, first, cyc, heff;
    build(rd, sl, ad, sz, wd);
    n = exp_n;
    heff = (hp == 0) ? 1 : hp;
    @(negedge clk);
    req_rd = rd; req_slave = sl; req_addr = ad; req_size = sz;
    req_wdata = wd; half = hp; req_valid = 1'b1;
    cap_n = 0; oe_bad = 0; edge_bad = 0; cap_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc = 1;
    if (noisy) begin
      // R9: a different request offered while busy must change nothing
      req_rd = ~rd; req_slave = ~sl; req_addr = ~ad; req_size = sz + 2'd1;
      req_wdata = ~wd; half = hp + 8'd2;
      chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
    end else begin
      req_valid = 1'b0;
    end
    while (!done && cyc < 20000) begin
      if (noisy && cap_n >= n) req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    half = hp;
    cap_en = 1'b0;
    bad = 0; first = -1;
    for (int i = 0; i < n; i++)
      if (capt[i] != exp_b[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, "R1 R2 R3 R4 R5", {tag, " frame bits (first bad index)"}, first, -1);
    bad = 0;
    for (int i = n; i < n + 16 && i < 128; i++) if (capt[i] != 1'b0) bad++;
    chk(bad == 0, "R7", {tag, " echo bits not line-high"}, bad, 0);
    chk(cap_n == n + 16, "R5 R7", {tag, " link clock periods"}, cap_n, n + 16);
    chk(oe_bad == 0, "R8", {tag, " oe/dir low during frame"}, oe_bad, 0);
    chk(edge_bad == 0, "R6", {tag, " data edge while clock high"}, edge_bad, 0);
    chk(cyc == 2 * heff * (n + 16) + 1, "R6 R10", {tag, " cycles to done"},
        cyc, 2 * heff * (n + 16) + 1);
    @(negedge clk);
    chk(done == 1'b0, "R10", {tag, " done width"}, done, 0);
    chk(loe == 1'b0 && xdir == 1'b0 && req_ready == 1'b1, "R8 R9",
        {tag, " idle line control"}, {loe, xdir, req_ready}, 3'b001);
    repeat (5) @(negedge clk);
    chk(req_ready == 1'b1 && lclk == 1'b1 && ldat == 1'b1, "R9", {tag, " no second frame"},
        {req_ready, lclk, ldat}, 3'b111);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready && lclk && ldat && !loe && !xdir && !done, "R11", "reset outputs",
        {req_ready, lclk, ldat, loe, xdir, done}, 6'b111000);
  endtask

  task automatic t_writes;
    run_frame("R3 write8",  1'b0, 2'd0, 21'h000001, 2'd0, 32'h0000_00A5, 8'd1, 1'b0);
    run_frame("R3 write16", 1'b0, 2'd2, 21'h15A5A4, 2'd1, 32'h0000_C3E1, 8'd1, 1'b0);
    run_frame("R2 write32", 1'b0, 2'd3, 21'h1FFFFE, 2'd2, 32'hDEAD_BEEF, 8'd1, 1'b0);
  endtask

  task automatic t_reads;
    run_frame("R1 read8",   1'b1, 2'd1, 21'h0ABCDE, 2'd0, 32'hFFFF_FFFF, 8'd1, 1'b0);
    run_frame("R2 read32c3",1'b1, 2'd0, 21'h100000, 2'd3, 32'h0, 8'd1, 1'b0);
  endtask

  task automatic t_divider;
    run_frame("R6 half0", 1'b0, 2'd1, 21'h000400, 2'd1, 32'h0000_1234, 8'd0, 1'b0);
    run_frame("R6 half3", 1'b1, 2'd3, 21'h0F0F0F, 2'd1, 32'h0, 8'd3, 1'b0);
  endtask

  task automatic t_busy;
    run_frame("R9 busy", 1'b0, 2'd2, 21'h0055AA, 2'd0, 32'h0000_003C, 8'd2, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_writes;
    t_reads;
    t_divider;
    t_busy;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule